// File: doc/BRIEF.md
# Programmable Logic Cell with Lookup Tables and Configurable Registers

This block is one programmable logic tile. Two 4-input lookup tables turn two separate groups of four logic inputs into the functions F and G. A third, 3-input lookup table combines F, G and an auxiliary input into H. Two output selectors bring any of F, G or H out as the combinational outputs `out_a` and `out_b`. Two storage flops drive the registered outputs `reg_a` and `reg_b`. Each flop takes its data from F, G, H or the bypass input `byp_in`. Each flop also has its own choice of capture edge, a choice of whether the shared `frc_in` input sets or clears it asynchronously, and a choice of whether the shared `en_in` input gates its captures.

All of this is held in a configuration register. Software or a loader shifts that register in one bit per clock through `cfg_in` while `cfg_en` is high. While loading is in progress, both flops are held clear. Once `cfg_en` drops, the cell runs as a fixed function until the next load. The first bit shifted in ends up at bit 0. The layout from bit 0 upward is: the F table (16 bits), the G table (16), the H table (8), output select A (2), output select B (2), data select A (2), data select B (2), edge A, edge B, force mode A, force mode B, enable use A and enable use B. That makes 54 bits in total.

Top module: `logic_cell`

## Requirements
- R1: `out` of the F table is the F-table bit indexed by `a_in` read as an unsigned number (bit 0..15). The G table works the same way with `b_in`, taking config bits 16..31.
- R2: H is config bit 32 + {aux_in, G, F}, where `aux_in` is the most significant bit of that 3-bit index and F is the least significant.
- R3: An output select code of 0 shows F, 1 shows G, and 2 or 3 shows H. The code for `out_a` is at bits 41:40 and the code for `out_b` is at bits 43:42.
- R4: A data select code of 0 captures F, 1 captures G, 2 captures H and 3 captures `byp_in`. The code for `reg_a` is at bits 45:44 and the code for `reg_b` is at bits 47:46.
- R5: When its edge bit is 0, a flop captures on the rising edge of `clk`; when it is 1, on the falling edge. The edge bit for `reg_a` is bit 48 and the edge bit for `reg_b` is bit 49.
- R6: While `frc_in` is high, a flop whose force-mode bit is 1 is set to 1 and a flop whose force-mode bit is 0 is cleared. This takes effect at once, without waiting for a clock edge, and it overrides any capture. The force-mode bit for A is bit 50 and for B is bit 51.
- R7: When a flop's enable-use bit is 1, it captures only at edges where `en_in` is high and otherwise keeps its value. When that bit is 0, `en_in` is ignored. The enable-use bit for A is bit 52 and for B is bit 53.
- R8: While `cfg_en` is high, each rising edge shifts `cfg_in` into bit 53 and moves every bit down by one position. While `cfg_en` is low, the configuration does not change, whatever `cfg_in` does.
- R9: While `cfg_en` is high, both registered outputs are held at 0.
- R10: Holding `rst_n` low over a rising edge of `clk` clears the whole configuration and both flops. This makes every output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable; holds flops clear |
| cfg_in | input | 1 | Serial configuration data |
| a_in | input | 4 | Index inputs of the F table |
| b_in | input | 4 | Index inputs of the G table |
| aux_in | input | 1 | Extra index input of the H table |
| byp_in | input | 1 | Direct flop data input |
| frc_in | input | 1 | Shared asynchronous set/clear request |
| en_in | input | 1 | Shared capture enable |
| out_a | output | 1 | Combinational output A |
| out_b | output | 1 | Combinational output B |
| reg_a | output | 1 | Registered output A |
| reg_b | output | 1 | Registered output B |

## Verification
Two functions can fall in the same cycle: the asynchronous force and an enabled capture edge. The bench provokes this directly. It raises `frc_in` across a clock edge while `en_in` is high and the flop's data input is the opposite of the forced value. The forced value must survive that edge, and the captured value may appear only after `frc_in` drops. Random configurations also assert `frc_in` in about one step in eight, alongside live inputs and edges. A bench model of the tables, selectors and flops then judges each step.

// File: rtl/lc_pkg.sv
// lc_pkg: shared codes and the selector helper for the logic cell.
// Assumes 2-bit select fields; the codes are part of the configuration format.
package lc_pkg;

    localparam logic [1:0] SRC_F   = 2'd0;
    localparam logic [1:0] SRC_G   = 2'd1;
    localparam logic [1:0] SRC_H   = 2'd2;
    localparam logic [1:0] SRC_ALT = 2'd3;

    // Pick one of four sources by code; callers choose what the fourth is.
    function automatic logic pick(input logic [1:0] code, input logic f,
                                  input logic g, input logic h, input logic alt);
        logic r;
        case (code)
            SRC_F:   r = f;
            SRC_G:   r = g;
            SRC_H:   r = h;
            default: r = alt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lc_cfg_chain.sv
// lc_cfg_chain: serial configuration register.
// Shifts sin into the top bit while en is high, so the first bit loaded
// ends at bit 0 after W shifts. Holds its contents otherwise. Synchronous
// active-low reset clears it.
module lc_cfg_chain #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         sin,
    output logic [W-1:0] cfg
);

    // Shift or hold the configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (en)
            cfg <= {sin, cfg[W-1:1]};
    end

    // R8: configuration is frozen while loading is off
    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cfg));

endmodule

// File: rtl/lc_lut.sv
// lc_lut: K-input lookup table whose truth table comes from configuration.
// Assumes tbl bit i holds the function value for index value i.
module lc_lut #(
    parameter int K = 4,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] tbl,
    input  logic [K-1:0] idx,
    output logic         y
);

    // Read the minterm addressed by the inputs.
    always_comb y = tbl[idx];

endmodule

// File: rtl/lc_flop.sv
// lc_flop: one configurable storage flop.
// Capture edge is chosen by inverting the clock; frc forces set or clear
// asynchronously per set_mode; ce_use makes en gate captures; hold (config
// load) clears it asynchronously and wins over a set. Sync reset on rst_n.
// Assumes inv and set_mode only change while hold is high.
module lc_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic inv,
    input  logic set_mode,
    input  logic ce_use,
    input  logic d,
    input  logic en,
    input  logic frc,
    output logic q
);

    logic fclk;
    logic a_set;
    logic a_clr;

    // Derive the capture clock and the asynchronous controls.
    always_comb begin
        fclk  = clk ^ inv;
        a_clr = hold | (frc & ~set_mode);
        a_set = frc & set_mode & ~hold;
    end

    // Storage with asynchronous set/clear over gated capture.
    always_ff @(posedge fclk or posedge a_clr or posedge a_set) begin
        if (a_clr)
            q <= 1'b0;
        else if (a_set)
            q <= 1'b1;
        else if (!rst_n)
            q <= 1'b0;
        else if (!ce_use || en)
            q <= d;
    end

    // R6: a forcing request in set mode shows 1
    a_r6_force_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frc && set_mode && !hold) |-> q);

    // R6: a forcing request in clear mode shows 0
    a_r6_force_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (frc && !set_mode) |-> !q);

    // R7: a rising-edge flop with gating keeps its value when en is low
    a_r7_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv && ce_use && !en && !frc && !hold) |=> (frc || hold || q == $past(q)));

endmodule

// File: rtl/logic_cell.sv
// logic_cell: programmable logic tile with F/G/H lookup tables, two output
// selectors and two configurable flops, configured through a serial chain.
// Assumes the configuration is loaded with cfg_en high before use; the bit
// layout, from bit 0, is F table, G table, H table, output selects,
// data selects, edge bits, force-mode bits, enable-use bits.
module logic_cell #(
    parameter int K = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_en,
    input  logic         cfg_in,
    input  logic [K-1:0] a_in,
    input  logic [K-1:0] b_in,
    input  logic         aux_in,
    input  logic         byp_in,
    input  logic         frc_in,
    input  logic         en_in,
    output logic         out_a,
    output logic         out_b,
    output logic         reg_a,
    output logic         reg_b
);

    localparam int TW       = 1 << K;
    localparam int HK       = 3;
    localparam int HW       = 1 << HK;
    localparam int NSLOT    = 2;
    localparam int OFF_G    = TW;
    localparam int OFF_H    = 2 * TW;
    localparam int OFF_OSEL = OFF_H + HW;
    localparam int OFF_DSEL = OFF_OSEL + 2 * NSLOT;
    localparam int OFF_EDGE = OFF_DSEL + 2 * NSLOT;
    localparam int OFF_SRM  = OFF_EDGE + NSLOT;
    localparam int OFF_CEU  = OFF_SRM + NSLOT;
    localparam int CW       = OFF_CEU + NSLOT;

    logic [CW-1:0]    cfg;
    logic             f_v;
    logic             g_v;
    logic             h_v;
    logic [NSLOT-1:0] comb_v;
    logic [NSLOT-1:0] reg_v;

    lc_cfg_chain #(.W(CW)) u_chain (
        .clk (clk),
        .rst_n(rst_n),
        .en  (cfg_en),
        .sin (cfg_in),
        .cfg (cfg)
    );

    lc_lut #(.K(K)) u_lut_f (
        .tbl(cfg[TW-1:0]),
        .idx(a_in),
        .y  (f_v)
    );

    lc_lut #(.K(K)) u_lut_g (
        .tbl(cfg[OFF_G +: TW]),
        .idx(b_in),
        .y  (g_v)
    );

    lc_lut #(.K(HK)) u_lut_h (
        .tbl(cfg[OFF_H +: HW]),
        .idx({aux_in, g_v, f_v}),
        .y  (h_v)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [1:0] osel;
        logic [1:0] dsel;
        logic       d_v;

        // Decode this slot's selector fields and pick its sources.
        always_comb begin
            osel      = cfg[OFF_OSEL + 2*i +: 2];
            dsel      = cfg[OFF_DSEL + 2*i +: 2];
            comb_v[i] = lc_pkg::pick(osel, f_v, g_v, h_v, h_v);
            d_v       = lc_pkg::pick(dsel, f_v, g_v, h_v, byp_in);
        end

        lc_flop u_ff (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (cfg_en),
            .inv     (cfg[OFF_EDGE + i]),
            .set_mode(cfg[OFF_SRM + i]),
            .ce_use  (cfg[OFF_CEU + i]),
            .d       (d_v),
            .en      (en_in),
            .frc     (frc_in),
            .q       (reg_v[i])
        );
    end

    // Drive the ports from the slot vectors.
    always_comb begin
        out_a = comb_v[0];
        out_b = comb_v[1];
        reg_a = reg_v[0];
        reg_b = reg_v[1];
    end

    // R9: loading keeps both flops clear
    a_r9_load_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (reg_a == 1'b0 && reg_b == 1'b0));

    // R3: selector code 0 presents the F table on output A
    a_r3_sel_f: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[OFF_OSEL +: 2] == lc_pkg::SRC_F) |-> (out_a == f_v));

endmodule

// File: tb/tb_logic_cell.sv
module tb_logic_cell;

    localparam int CW = 54;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       aux_in = 1'b0;
    logic       byp_in = 1'b0;
    logic       frc_in = 1'b0;
    logic       en_in = 1'b0;
    logic       out_a, out_b, reg_a, reg_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [CW-1:0] cb;
    logic [1:0]    mq;
    logic [3:0]    p_a, p_b;
    logic          p_aux, p_byp, p_frc, p_en;

    logic_cell dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in),
        .a_in(a_in), .b_in(b_in), .aux_in(aux_in), .byp_in(byp_in),
        .frc_in(frc_in), .en_in(en_in),
        .out_a(out_a), .out_b(out_b), .reg_a(reg_a), .reg_b(reg_b)
    );

    always #2 clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic m_f(input logic [3:0] a);
        return cb[a];
    endfunction
    function automatic logic m_g(input logic [3:0] b);
        return cb[16 + b];
    endfunction
    function automatic logic m_h(input logic [3:0] a, input logic [3:0] b, input logic x);
        return cb[32 + {x, m_g(b), m_f(a)}];
    endfunction
    function automatic logic m_out(input int i, input logic [3:0] a,
                                   input logic [3:0] b, input logic x);
        logic [1:0] s = cb[40 + 2*i +: 2];
        if (s == 2'd0) return m_f(a);
        if (s == 2'd1) return m_g(b);
        return m_h(a, b, x);
    endfunction
    function automatic logic m_d(input int i, input logic [3:0] a, input logic [3:0] b,
                                 input logic x, input logic y);
        logic [1:0] s = cb[44 + 2*i +: 2];
        if (s == 2'd0) return m_f(a);
        if (s == 2'd1) return m_g(b);
        if (s == 2'd2) return m_h(a, b, x);
        return y;
    endfunction

    task automatic remember();
        p_a = a_in; p_b = b_in; p_aux = aux_in; p_byp = byp_in;
        p_frc = frc_in; p_en = en_in;
    endtask

    // Shift a configuration in, bit 0 first, checking the held-clear flops.
    task automatic load(input logic [CW-1:0] bits);
        @(posedge clk); #1;
        frc_in = 1'b0;
        cfg_en = 1'b1;
        cfg_in = bits[0];
        #0.5;
        chk(reg_a, 1'b0, "R9 reg_a during load");
        chk(reg_b, 1'b0, "R9 reg_b during load");
        for (int i = 1; i < CW; i++) begin
            @(posedge clk); #1;
            cfg_in = bits[i];
        end
        @(posedge clk); #1;
        chk(reg_a | reg_b, 1'b0, "R9 both regs before release");
        cfg_en = 1'b0;
        cb = bits;
        mq = 2'b00;
        remember();
    endtask

    // One cycle: apply edge effects of the previous inputs, then drive new ones.
    task automatic step(input logic [3:0] a, input logic [3:0] b, input logic x,
                        input logic y, input logic frc, input logic en,
                        input logic cin, input string tag);
        @(posedge clk); #1;
        for (int i = 0; i < 2; i++)
            if (!p_frc && (!cb[52 + i] || p_en))
                mq[i] = m_d(i, p_a, p_b, p_aux, p_byp);
        chk(reg_a, mq[0], {tag, " R4 R5 R7 reg_a capture"});
        chk(reg_b, mq[1], {tag, " R4 R5 R7 reg_b capture"});
        a_in = a; b_in = b; aux_in = x; byp_in = y; frc_in = frc; en_in = en; cfg_in = cin;
        if (frc)
            for (int i = 0; i < 2; i++) mq[i] = cb[50 + i];
        #0.5;
        chk(out_a, m_out(0, a, b, x), {tag, " R1 R2 R3 out_a"});
        chk(out_b, m_out(1, a, b, x), {tag, " R1 R2 R3 out_b"});
        chk(reg_a, mq[0], {tag, " R6 reg_a force"});
        chk(reg_b, mq[1], {tag, " R6 reg_b force"});
        remember();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] c;
        void'($urandom(32'h1c3a));
        cb = '0; mq = '0;
        remember();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        // R10: reset state
        chk(out_a, 1'b0, "R10 out_a after reset");
        chk(out_b, 1'b0, "R10 out_b after reset");
        chk(reg_a, 1'b0, "R10 reg_a after reset");
        chk(reg_b, 1'b0, "R10 reg_b after reset");

        // R5: A on rising edge, B on falling edge, both capture byp_in
        c = '0;
        c[47:44] = 4'b1111;
        c[49] = 1'b1;
        load(c);
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 settle");
        @(posedge clk); #1;
        byp_in = 1'b1;
        #0.5;
        chk(reg_a, 1'b0, "R5 reg_a before any edge");
        chk(reg_b, 1'b0, "R5 reg_b before falling edge");
        #1;
        chk(reg_b, 1'b1, "R5 reg_b after falling edge");
        chk(reg_a, 1'b0, "R5 reg_a unchanged at falling edge");
        @(posedge clk); #1;
        chk(reg_a, 1'b1, "R5 reg_a after rising edge");
        mq = 2'b11;
        remember();

        // R10: sync reset clears configuration and flops
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        #1.5;
        chk(reg_a, 1'b0, "R10 reg_a cleared");
        chk(reg_b, 1'b0, "R10 reg_b cleared");
        byp_in = 1'b0;
        cb = '0; mq = '0;
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 post");

        // R6 and R7 with a concurrent edge: A clear-mode, B set-mode, both gated
        c = '0;
        c[47:44] = 4'b1111;
        c[51] = 1'b1;
        c[53:52] = 2'b11;
        load(c);
        step(4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 force with enabled edge");
        step(4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R6 force held over edge");
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 release, gate low");
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 gate low keeps");
        chk(reg_b, 1'b1, "R7 reg_b kept while gate low");
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7 gate high");
        step(4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7 captured");
        chk(reg_b, 1'b0, "R7 reg_b captured with gate high");

        // R8: cfg_in toggling with loading off leaves the function unchanged
        c = '0;
        c[15:0] = 16'h8001;
        c[43:40] = 4'b0100;
        load(c);
        step(4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 toggle a");
        step(4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 toggle b");
        step(4'hF, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 toggle c");
        chk(out_a, 1'b1, "R8 out_a still F table bit 15");

        // Random configurations and inputs
        for (int n = 0; n < 40; n++) begin
            c = {$urandom, $urandom};
            load(c);
            for (int s = 0; s < 60; s++)
                step($urandom, $urandom, $urandom, $urandom,
                     ($urandom % 8) == 0, $urandom, $urandom, "RND");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule